// File: doc/BRIEF.md
# Secure Scan Chain Register

This block is a short scan-chain segment of K flops that scrambles its own contents whenever it shifts, so that nobody who treats it as an ordinary shift register can load or read it correctly. In functional mode every flop takes a bit from the core logic in parallel. In scan mode the flops form a chain with a single mixing point. The last stage takes the bit of the stage before it, XORed with the product of the first stage and the live scan input.

Two inverters, each selected by a parameter, break any resemblance to a plain shift register. One sits at the head of the chain, between the scan input and the first flop. The other sits between the last stage and the scan output. A further parameter adds one extra flop in front of the scan output. A test program that knows the structure can still load any state in exactly K shift cycles, from any starting state. It can also recover the present state from the K output bits seen while it shifts in the next pattern, so loading and unloading overlap just as in a conventional chain. The mixing and inverting logic feeds only the scan side of the next-state multiplexer. The functional capture path therefore gains no logic.

Top module: `secure_scan_chain`

## Requirements
- R1: A clock edge with rst_n low clears every stage, the optional extra flop included. After reset core_q is all zeros and scan_out equals INV_OUT.
- R2: With scan_en low, core_q takes core_d at the next edge (bit i of core_q holds stage i+1). Without the extra flop, scan_out then shows core_d[K-1] XOR INV_OUT.
- R3: With scan_en high, one edge sets stage 1 to scan_in XOR INV_IN. Each stage i from 2 to K-1 takes stage i-1. Stage K takes stage K-1 XOR (stage 1 AND scan_in), using the values from before the edge.
- R4: In a continuous scan stream, the bit seen at scan_out K edges after input x(t) is x(t) ^ INV_IN ^ ((x(t+K-2) ^ INV_IN) & x(t+K-1)) ^ INV_OUT. The extra flop adds one edge to this.
- R5: Any target state s can be loaded in exactly K scan edges from any start. With K=3 the inputs in order are s3^I^(s2&(s1^I)), then s2^I, then s1^I, where I is INV_IN.
- R6: The present state s can be recovered from the K scan_out bits z0..z2 seen while shifting inputs x0..x2 (K=3, with O equal to INV_OUT): s3=z0^O, s1=z2^O^((x0^I)&x1), s2=z1^O^(s1&x0).
- R7: With INV_IN set, after K scan edges stage 1 never equals the last input bit, and stage 2 never equals the bit before it. A plain shift register reading of the loaded state is therefore always wrong.
- R8: With INV_OUT set, the first scan_out bit of an unload never equals the last stage's true content.
- R9: With the extra flop selected, the flop takes stage K on each scan edge and holds its value in functional mode. scan_out is that flop XOR INV_OUT, which makes the unload one edge longer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | 1 selects scan shifting, 0 selects functional capture |
| scan_in | input | 1 | Serial scan data in |
| core_d | input | K | Parallel capture data from the core |
| core_q | output | K | Stage contents to the core, bit i is stage i+1 |
| scan_out | output | 1 | Serial scan data out |

## Verification
Every flop captures on a rising edge, and scan_out is combinational from a flop. A capture result or a single-shift result therefore appears one edge after its inputs are applied. A stream bit reaches scan_out after K edges, or after K+1 edges with the extra flop. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so each reading falls exactly one rising edge after its stimulus. The load/unload sweep drives all 64 pairs of start state and target state. Before each shift it compares the unload bit against the closed-form value for that position. After the K-th shift it reads back the final state. The stream test keeps its own history of inputs and compares only from the K-th edge onward.

// File: rtl/ssc_pkg.sv
// Shared definitions for the secure scan chain.
// Assumes a chain of at least three stages.
package ssc_pkg;
    localparam int SSC_MIN_STAGES = 3;

    // Feed-forward product that is mixed into the last stage.
    function automatic logic ssc_mix(input logic head_bit, input logic live_in);
        return head_bit & live_in;
    endfunction
endpackage

// File: rtl/ssc_next.sv
// Next-state logic of the secure scan chain.
// Scan mode: head inverter, plain middle stages, XOR mixing into the last stage.
// Functional mode: parallel core data passes straight through, so the scan
// logic never sits on the capture path.
module ssc_next
    import ssc_pkg::*;
#(
    parameter int K      = 3,
    parameter bit INV_IN = 1'b1
) (
    input  logic         scan_en,
    input  logic         scan_in,
    input  logic [K-1:0] cur,
    input  logic [K-1:0] core_d,
    output logic [K-1:0] nxt
);
    logic [K-1:0] shifted;

    // Head stage: scan input, optionally inverted.
    assign shifted[0] = scan_in ^ INV_IN;

    // Middle stages: plain shift.
    generate
        for (genvar i = 1; i < K - 1; i++) begin : g_mid
            assign shifted[i] = cur[i-1];
        end
    endgenerate

    // Last stage: previous stage XOR (head stage AND live scan input).
    assign shifted[K-1] = cur[K-2] ^ ssc_mix(cur[0], scan_in);

    // Mode select: scan path or functional capture.
    always_comb begin
        nxt = scan_en ? shifted : core_d;
    end
endmodule

// File: rtl/ssc_regs.sv
// A bank of W flops with synchronous active-low reset to zero.
// Assumes the caller presents the complete next value each cycle.
module ssc_regs #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Register update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/secure_scan_chain.sv
// Top of the secure scan chain segment.
// Combines the next-state logic, the stage flops and the scan output stage.
// The output stage has an optional extra flop and an optional inverter.
// Assumes K >= 3.
module secure_scan_chain #(
    parameter int K       = 3,
    parameter bit INV_IN  = 1'b1,
    parameter bit INV_OUT = 1'b1,
    parameter bit DUMMY   = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scan_en,
    input  logic         scan_in,
    input  logic [K-1:0] core_d,
    output logic [K-1:0] core_q,
    output logic         scan_out
);
    logic [K-1:0] stage_nxt;
    logic [K-1:0] stage_q;
    logic         tail_bit;

    ssc_next #(.K(K), .INV_IN(INV_IN)) u_next (
        .scan_en (scan_en),
        .scan_in (scan_in),
        .cur     (stage_q),
        .core_d  (core_d),
        .nxt     (stage_nxt)
    );

    ssc_regs #(.W(K)) u_stages (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stage_nxt),
        .q     (stage_q)
    );

    // Output stage: optional extra flop between the last stage and the pin.
    generate
        if (DUMMY) begin : g_dummy
            logic [0:0] dum_d;
            logic [0:0] dum_q;
            // Extra flop shifts in scan mode and holds in functional mode.
            always_comb begin
                dum_d[0] = scan_en ? stage_q[K-1] : dum_q[0];
            end
            ssc_regs #(.W(1)) u_dum (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (dum_d),
                .q     (dum_q)
            );
            assign tail_bit = dum_q[0];
        end else begin : g_direct
            assign tail_bit = stage_q[K-1];
        end
    endgenerate

    assign core_q   = stage_q;
    assign scan_out = tail_bit ^ INV_OUT;
endmodule

// File: rtl/ssc_chk.sv
// Checker for the secure scan chain, bound to every instance of the top.
// Observes only the top's ports.
module ssc_chk #(
    parameter int K       = 3,
    parameter bit INV_IN  = 1'b1,
    parameter bit INV_OUT = 1'b1,
    parameter bit DUMMY   = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scan_en,
    input logic         scan_in,
    input logic [K-1:0] core_d,
    input logic [K-1:0] core_q,
    input logic         scan_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (core_q == '0));

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> (core_q == $past(core_d)));

    // R3
    head_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (core_q[0] == ($past(scan_in) ^ INV_IN)));

    // R3
    mid_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (core_q[K-2:1] == $past(core_q[K-3:0])));

    // R3
    last_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (core_q[K-1] == $past(core_q[K-2] ^ (core_q[0] & scan_in))));

    generate
        if (DUMMY) begin : g_dum_chk
            // R9
            dummy_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                scan_en |=> (scan_out == ($past(core_q[K-1]) ^ INV_OUT)));
            // R9
            dummy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !scan_en |=> $stable(scan_out));
        end else begin : g_direct_chk
            // R8
            out_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                scan_en |=> (scan_out ==
                    ($past(core_q[K-2] ^ (core_q[0] & scan_in)) ^ INV_OUT)));
        end
    endgenerate
endmodule

bind secure_scan_chain ssc_chk #(
    .K(K), .INV_IN(INV_IN), .INV_OUT(INV_OUT), .DUMMY(DUMMY)
) u_ssc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .core_d   (core_d),
    .core_q   (core_q),
    .scan_out (scan_out)
);

// File: tb/secure_scan_chain_test.sv
`timescale 1ns/1ps
// Bench: three 3-stage variants driven in lockstep.
// uut is fully secured, plain has no inverters, dum is secured with the extra flop.
module secure_scan_chain_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b0;
    logic       scan_in = 1'b0;
    logic [2:0] core_d = 3'b000;
    logic [2:0] q_u, q_p, q_d;
    logic       so_u, so_p, so_d;
    int         vectors = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic       xs [0:99];

    always #10 clk = ~clk;

    secure_scan_chain #(.K(3), .INV_IN(1'b1), .INV_OUT(1'b1), .DUMMY(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .core_d(core_d), .core_q(q_u), .scan_out(so_u));
    secure_scan_chain #(.K(3), .INV_IN(1'b0), .INV_OUT(1'b0), .DUMMY(1'b0)) plain (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .core_d(core_d), .core_q(q_p), .scan_out(so_p));
    secure_scan_chain #(.K(3), .INV_IN(1'b1), .INV_OUT(1'b1), .DUMMY(1'b1)) dum (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .core_d(core_d), .core_q(q_d), .scan_out(so_d));

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply inputs at a falling edge, pass one rising edge, return at the next falling edge.
    task automatic step(input logic se, input logic si, input logic [2:0] d);
        scan_en = se;
        scan_in = si;
        core_d  = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Unload bit j for start state s, inputs x, head inversion ih, output inversion io.
    function automatic logic zexp(input logic [2:0] s, input logic [2:0] x,
                                  input int j, input logic ih, input logic io);
        logic b;
        if (j == 0)      b = s[2];
        else if (j == 1) b = s[1] ^ (s[0] & x[0]);
        else             b = s[0] ^ ((x[0] ^ ih) & x[1]);
        return b ^ io;
    endfunction

    initial begin
        #1ms;
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        @(negedge clk);
        step(1'b0, 1'b0, 3'b000);
        step(1'b0, 1'b0, 3'b000);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 uut core_q", q_u, 0);
        chk("R1 uut scan_out", so_u, 1);
        chk("R1 plain scan_out", so_p, 0);
        chk("R1 dum core_q", q_d, 0);
        chk("R1 dum scan_out", so_d, 1);

        // Load/unload sweep over every start state and target state.
        for (int st = 0; st < 8; st++) begin
            for (int tg = 0; tg < 8; tg++) begin
                logic [2:0] s, t, x, z, rec;
                logic prev_d;
                s = 3'(st);
                t = 3'(tg);
                prev_d = so_d;
                step(1'b0, 1'b0, s);
                // R2 functional capture
                chk("R2 uut core_q", q_u, s);
                chk("R2 plain core_q", q_p, s);
                chk("R2 uut scan_out", so_u, s[2] ^ 1'b1);
                chk("R2 plain scan_out", so_p, s[2]);
                // R9 extra flop holds in functional mode
                chk("R9 dum hold", so_d, prev_d);
                // R5 input sequence for the target, head inversion on
                x[2] = t[0] ^ 1'b1;
                x[1] = t[1] ^ 1'b1;
                x[0] = t[2] ^ 1'b1 ^ (t[1] & (t[0] ^ 1'b1));
                for (int j = 0; j < 3; j++) begin
                    z[j] = so_u;
                    chk("R6 uut unload bit", so_u, zexp(s, x, j, 1'b1, 1'b1));
                    chk("R3 plain unload bit", so_p, zexp(s, x, j, 1'b0, 1'b0));
                    if (j == 0) chk("R8 first bit differs", so_u != s[2], 1);
                    if (j >= 1) chk("R9 dum delayed bit", so_d, zexp(s, x, j - 1, 1'b1, 1'b1));
                    step(1'b1, x[j], 3'b000);
                end
                // R6 recover start state from the unload
                rec[2] = z[0] ^ 1'b1;
                rec[0] = z[2] ^ 1'b1 ^ ((x[0] ^ 1'b1) & x[1]);
                rec[1] = z[1] ^ 1'b1 ^ (rec[0] & x[0]);
                chk("R6 recovered state", rec, s);
                // R5 target loaded in three edges
                chk("R5 uut target", q_u, t);
                chk("R5 dum target", q_d, t);
                chk("R3 plain final", q_p, {x[0] ^ (x[1] & x[2]), x[1], x[2]});
                // R7 no plain shift reading of the load
                chk("R7 stage1 differs", q_u[0] != x[2], 1);
                chk("R7 stage2 differs", q_u[1] != x[1], 1);
            end
        end

        // R4 continuous stream from an LFSR.
        lf = 8'hA5;
        for (int n = 0; n < 100; n++) begin
            xs[n] = lf[0];
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        end
        for (int n = 0; n < 100; n++) begin
            int m;
            step(1'b1, xs[n], 3'b000);
            m = n + 1;
            if (m >= 3) begin
                chk("R4 uut stream", so_u,
                    xs[m-3] ^ 1'b1 ^ ((xs[m-2] ^ 1'b1) & xs[m-1]) ^ 1'b1);
                chk("R4 plain stream", so_p, xs[m-3] ^ (xs[m-2] & xs[m-1]));
            end
            if (m >= 4) begin
                chk("R9 dum stream", so_d,
                    xs[m-4] ^ 1'b1 ^ ((xs[m-3] ^ 1'b1) & xs[m-2]) ^ 1'b1);
            end
        end

        // R1 reset in mid-run
        step(1'b0, 1'b0, 3'b111);
        rst_n = 1'b0;
        step(1'b1, 1'b1, 3'b111);
        rst_n = 1'b1;
        chk("R1 uut mid reset", q_u, 0);
        chk("R1 dum mid reset out", so_d, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule